// File: doc/BRIEF.md
# Queued Interrupt Aggregation Controller

This block collects interrupt events from sixteen I/O channels and from six device-level monitors and drives one active-low interrupt line. Each channel can report a filtered input change or, while it is in output mode, an overcurrent that has lasted for a programmable number of cycles. The device monitors report undervoltage on two supplies, a supply burst, end of A/D conversion and two over-temperature stages. These device events cannot be masked.

All events enabled in one clock cycle form one record: a set of source flags plus a change mask and an overcurrent mask. Records go into a queue of eight entries. The status outputs show only the record at the head of the queue. A one-cycle end-of-interrupt strobe discards the head, so the strobe clears itself and software never writes it back to zero. The interrupt line returns high only when the queue is empty. If the queue is full, new events are merged into the newest record and an overflow flag is raised. When any channel switches from input mode to output mode, every queued message is discarded.

Top module: `irq_queue_ctrl`

## Requirements
- R1: After reset, irq_no is 1 and int_stat_o, chg_stat_o, oc_stat_o and ovf_o are all 0. Whenever irq_no is 1, all three status outputs are 0.
- R2: A pulse on chg_evt_i[c] with chg_en_i[c]=1 creates a record. One cycle later irq_no is 0, int_stat_o bit 0 is 1 and chg_stat_o[c] is 1. A pulse on a channel whose enable is 0 records nothing.
- R3: An overcurrent on channel c counts only while oc_i[c] and out_mode_i[c] are both 1. The event is recorded at the clock edge that ends the (oc_filt_i+1)-th consecutive qualified cycle. It sets int_stat_o bit 1 and oc_stat_o[c], and fires once for each qualified episode.
- R4: An overcurrent on a channel with oc_en_i[c]=0 records nothing.
- R5: dev_evt_i bits 0 to 5 (undervoltage supply 1, undervoltage supply 2, burst, end of conversion, temperature stage 1, temperature stage 2) cannot be masked. They appear on int_stat_o bits 2 to 7 respectively.
- R6: All enabled events in one cycle are combined into a single record, and one end-of-interrupt removes that record.
- R7: A pulse on eoi_wr_i removes the head record. irq_no stays 0 while records remain and goes to 1 when the queue becomes empty. A pulse on eoi_wr_i while the queue is empty has no effect.
- R8: The queue holds up to DEPTH=8 records and presents them in arrival order.
- R9: An event that arrives while the queue is full and no record is removed in that cycle is ORed into the newest record and sets ovf_o. ovf_o clears when the queue becomes empty.
- R10: If a record is removed and a new one arrives in the same cycle while the queue is full, the new record is stored normally and no merge takes place.
- R11: A 0-to-1 change on any bit of out_mode_i empties the queue and clears ovf_o, and events in that same cycle are dropped. A 1-to-0 change does not purge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chg_evt_i | input | 16 | Per-channel filtered input change pulses |
| chg_en_i | input | 16 | Per-channel change interrupt enables |
| oc_i | input | 16 | Per-channel raw overcurrent levels |
| oc_en_i | input | 16 | Per-channel overcurrent interrupt enables |
| oc_filt_i | input | 8 | Overcurrent filter time in cycles |
| out_mode_i | input | 16 | Per-channel output mode (1 = output) |
| dev_evt_i | input | 6 | Device monitor event pulses |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| irq_no | output | 1 | Active-low interrupt line |
| int_stat_o | output | 8 | Source flags of the head record |
| chg_stat_o | output | 16 | Change mask of the head record |
| oc_stat_o | output | 16 | Overcurrent mask of the head record |
| ovf_o | output | 1 | Queue overflow (merge) flag |

## Verification
Removing a record and adding a record can happen in the same cycle. The case that matters most is a full queue, because there the choice between merging and appending depends on whether a record is removed in that cycle. The bench fills the queue, then raises eoi_wr_i and a new change event on the same edge. The result is judged correct if ovf_o stays 0 and the new record comes out as the last of eight after the older ones. A second case combines a purge with an arriving event in one cycle, and the bench expects an empty queue afterwards.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 8;
  localparam int NUM_DEV  = 6;
  localparam int SRC_CHG  = 0;
  localparam int SRC_OC   = 1;
  localparam int SRC_DEV0 = 2;
endpackage

// File: rtl/irq_oc_filter.sv
module irq_oc_filter #(
  parameter int N_CH   = 16,
  parameter int FILT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   qual_i,
  input  logic [FILT_W-1:0] filt_i,
  output logic [N_CH-1:0]   fire_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [FILT_W-1:0] cnt_q;
    logic              done_q;
    assign fire_o[c] = qual_i[c] && (cnt_q >= filt_i) && !done_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!qual_i[c]) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else begin
        if (cnt_q < filt_i) cnt_q <= cnt_q + 1'b1;
        if (fire_o[c]) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_rec_fifo.sv
module irq_rec_fifo #(
  parameter int REC_W = 40,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             purge_i,
  input  logic [REC_W-1:0] rec_i,
  output logic [REC_W-1:0] head_o,
  output logic [CW-1:0]    cnt_o,
  output logic             ovf_o
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_q, wr_q, last_ptr;
  logic [CW-1:0]    cnt_q;
  logic             full, do_wr, do_merge;

  assign full     = (cnt_q == CW'(DEPTH));
  assign do_wr    = push_i && (!full || pop_i) && !purge_i;
  assign do_merge = push_i && full && !pop_i && !purge_i;
  assign last_ptr = wr_q - AW'(1);
  assign head_o   = mem[rd_q];
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wr_q] <= rec_i;
    else if (do_merge) mem[last_ptr] <= mem[last_ptr] | rec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else if (purge_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_wr) wr_q <= wr_q + AW'(1);
      if (pop_i) rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_wr) - CW'(pop_i);
      if (do_merge) ovf_o <= 1'b1;
      else if (pop_i && !do_wr && cnt_q == CW'(1)) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_queue_ctrl.sv
module irq_queue_ctrl
  import irq_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int DEPTH  = 8,
  parameter int FILT_W = 8,
  localparam int REC_W = NUM_SRC + 2 * N_CH,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CH-1:0]    chg_evt_i,
  input  logic [N_CH-1:0]    chg_en_i,
  input  logic [N_CH-1:0]    oc_i,
  input  logic [N_CH-1:0]    oc_en_i,
  input  logic [FILT_W-1:0]  oc_filt_i,
  input  logic [N_CH-1:0]    out_mode_i,
  input  logic [NUM_DEV-1:0] dev_evt_i,
  input  logic               eoi_wr_i,
  output logic               irq_no,
  output logic [NUM_SRC-1:0] int_stat_o,
  output logic [N_CH-1:0]    chg_stat_o,
  output logic [N_CH-1:0]    oc_stat_o,
  output logic               ovf_o
);
  logic [N_CH-1:0]    mode_q, oc_fire, chg_m, oc_m;
  logic [NUM_SRC-1:0] flags;
  logic [REC_W-1:0]   rec, head;
  logic [CW-1:0]      fifo_cnt;
  logic               push, pop, purge, empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= out_mode_i;
  end

  // input-to-output switch on any channel
  assign purge = |(out_mode_i & ~mode_q);

  irq_oc_filter #(.N_CH(N_CH), .FILT_W(FILT_W)) u_oc_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .qual_i (oc_i & out_mode_i),
    .filt_i (oc_filt_i),
    .fire_o (oc_fire)
  );

  assign chg_m = chg_evt_i & chg_en_i;
  assign oc_m  = oc_fire & oc_en_i;

  always_comb begin
    flags = '0;
    flags[SRC_CHG] = |chg_m;
    flags[SRC_OC]  = |oc_m;
    for (int d = 0; d < NUM_DEV; d++) flags[SRC_DEV0+d] = dev_evt_i[d];
  end

  assign rec   = {oc_m, chg_m, flags};
  assign push  = |flags;
  assign empty = (fifo_cnt == '0);
  assign pop   = eoi_wr_i && !empty && !purge;

  irq_rec_fifo #(.REC_W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .purge_i (purge),
    .rec_i   (rec),
    .head_o  (head),
    .cnt_o   (fifo_cnt),
    .ovf_o   (ovf_o)
  );

  assign irq_no     = empty;
  assign int_stat_o = empty ? '0 : head[NUM_SRC-1:0];
  assign chg_stat_o = empty ? '0 : head[NUM_SRC +: N_CH];
  assign oc_stat_o  = empty ? '0 : head[NUM_SRC+N_CH +: N_CH];
endmodule

// File: rtl/irq_queue_chk.sv
module irq_queue_chk #(
  parameter int N_CH  = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [5:0]    dev_evt_i,
  input logic          eoi_wr_i,
  input logic          irq_no,
  input logic [7:0]    int_stat_o,
  input logic [N_CH-1:0] chg_stat_o,
  input logic [N_CH-1:0] oc_stat_o,
  input logic          ovf_o,
  input logic          purge,
  input logic          push,
  input logic [CW-1:0] fifo_cnt
);
  p_idle_stat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no |-> (int_stat_o == '0 && chg_stat_o == '0 && oc_stat_o == '0));

  p_dev_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_evt_i != '0 && !purge) |=> !irq_no);

  p_eoi_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr_i && fifo_cnt > CW'(1) && !purge) |=> !irq_no);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  p_merge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && fifo_cnt == CW'(DEPTH) && !eoi_wr_i && !purge) |=> ovf_o);

  p_ovf_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(fifo_cnt) == CW'(DEPTH));

  p_purge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge |=> (irq_no && !ovf_o));
endmodule

bind irq_queue_ctrl irq_queue_chk #(.N_CH(N_CH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/irq_queue_ctrl_bench.sv
`timescale 1ns/1ps
module irq_queue_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] chg_evt_i = '0, chg_en_i = '0, oc_i = '0, oc_en_i = '0, out_mode_i = '0;
  logic [7:0]  oc_filt_i = '0;
  logic [5:0]  dev_evt_i = '0;
  logic        eoi_wr_i = 1'b0;
  logic        irq_no, ovf_o;
  logic [7:0]  int_stat_o;
  logic [15:0] chg_stat_o, oc_stat_o;
  int n_tests = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  irq_queue_ctrl u_irq_queue_ctrl (.*);

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic eoi();
    eoi_wr_i = 1'b1; tick(); eoi_wr_i = 1'b0;
  endtask

  task automatic chg_pulse(logic [15:0] m);
    chg_evt_i = m; tick(); chg_evt_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(irq_no), 1);
    chk("R1 int_stat", 32'(int_stat_o), 0);
    chk("R1 chg_stat", 32'(chg_stat_o), 0);
    chk("R1 oc_stat", 32'(oc_stat_o), 0);
    chk("R1 ovf", 32'(ovf_o), 0);
  endtask

  task automatic t_change();
    chg_en_i = 16'h00FF;
    chg_pulse(16'h0103);
    chk("R2 irq", 32'(irq_no), 0);
    chk("R2 int_stat", 32'(int_stat_o), 32'h01);
    chk("R2 chg_stat", 32'(chg_stat_o), 32'h0003);
    eoi();
    chk("R7 empty irq", 32'(irq_no), 1);
    chk("R1 idle stat", 32'(chg_stat_o), 0);
    chg_pulse(16'h0100);
    chk("R2 masked", 32'(irq_no), 1);
    eoi();
    chg_pulse(16'h0001);
    chk("R7 eoi on empty", 32'(irq_no), 0);
    eoi();
    chk("R7 eoi on empty drain", 32'(irq_no), 1);
  endtask

  task automatic t_oc();
    out_mode_i = 16'h0010; tick();
    oc_filt_i = 8'd3; oc_en_i = 16'hFFFF; oc_i = 16'h0030;
    tick(); tick(); tick();
    chk("R3 before filter", 32'(irq_no), 1);
    tick();
    chk("R3 irq", 32'(irq_no), 0);
    chk("R3 oc_stat", 32'(oc_stat_o), 32'h0010);
    chk("R3 int_stat", 32'(int_stat_o), 32'h02);
    tick(); tick(); tick();
    eoi();
    chk("R3 fires once", 32'(irq_no), 1);
    oc_i = '0; tick();
    oc_filt_i = 8'd0; oc_en_i = 16'hFFEF; oc_i = 16'h0010;
    tick(); tick();
    chk("R4 masked oc", 32'(irq_no), 1);
    oc_i = '0; tick();
    oc_en_i = 16'hFFFF; oc_i = 16'h0010; tick();
    chk("R3 zero filter", 32'(oc_stat_o), 32'h0010);
    oc_i = '0; eoi();
    out_mode_i = '0; tick();
    chk("R3 drained", 32'(irq_no), 1);
  endtask

  task automatic t_dev();
    chg_en_i = '0;
    dev_evt_i = 6'b100001; tick(); dev_evt_i = '0;
    chk("R5 irq", 32'(irq_no), 0);
    chk("R5 int_stat", 32'(int_stat_o), 32'h84);
    eoi();
    chg_en_i = 16'hFFFF;
    chg_evt_i = 16'h0400; dev_evt_i = 6'b000100; tick();
    chg_evt_i = '0; dev_evt_i = '0;
    chk("R6 combined flags", 32'(int_stat_o), 32'h11);
    chk("R6 combined mask", 32'(chg_stat_o), 32'h0400);
    eoi();
    chk("R6 single pop", 32'(irq_no), 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) begin
      dev_evt_i = 6'(1 << i); tick();
    end
    dev_evt_i = '0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 order", 32'(int_stat_o), 32'(4 << i));
      chk("R7 held low", 32'(irq_no), 0);
      eoi();
    end
    chk("R7 release", 32'(irq_no), 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) chg_pulse(16'(1 << i));
    chk("R9 no ovf at 8", 32'(ovf_o), 0);
    chg_pulse(16'h0100);
    chg_pulse(16'h0200);
    chk("R9 ovf", 32'(ovf_o), 1);
    for (int i = 0; i < 8; i++) begin
      chk("R9 heads", 32'(chg_stat_o), (i < 7) ? 32'(1 << i) : 32'h0380);
      eoi();
    end
    chk("R9 ovf clear", 32'(ovf_o), 0);
    chk("R9 empty", 32'(irq_no), 1);
  endtask

  task automatic t_same();
    for (int i = 0; i < 8; i++) chg_pulse(16'(1 << i));
    eoi_wr_i = 1'b1; chg_evt_i = 16'h0400; tick();
    eoi_wr_i = 1'b0; chg_evt_i = '0;
    chk("R10 no merge", 32'(ovf_o), 0);
    for (int k = 1; k <= 8; k++) begin
      chk("R10 heads", 32'(chg_stat_o), (k < 8) ? 32'(1 << k) : 32'h0400);
      eoi();
    end
    chk("R10 drained", 32'(irq_no), 1);
  endtask

  task automatic t_purge();
    chg_pulse(16'h0001);
    chg_pulse(16'h0002);
    out_mode_i = 16'h0008; chg_evt_i = 16'h0004; tick(); chg_evt_i = '0;
    chk("R11 purge irq", 32'(irq_no), 1);
    chk("R11 purge stat", 32'(int_stat_o), 0);
    out_mode_i = '0; chg_evt_i = 16'h0010; tick(); chg_evt_i = '0;
    chk("R11 falling keeps", 32'(chg_stat_o), 32'h0010);
    for (int i = 0; i < 9; i++) chg_pulse(16'(1 << i));
    chk("R11 ovf set", 32'(ovf_o), 1);
    out_mode_i = 16'h0001; tick();
    chk("R11 ovf cleared", 32'(ovf_o), 0);
    chk("R11 empty", 32'(irq_no), 1);
    out_mode_i = '0; tick();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_change();
    t_oc();
    t_dev();
    t_order();
    t_full();
    t_same();
    t_purge();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule